// File: doc/BRIEF.md
# Branch, call and return sequencer

This block owns the program counter and the two stack pointers of a small processor with 13-bit instruction words, a 16-bit program counter and nibble-wide data memory. When fetch presents a branch-group instruction with `start`, the block works out the next program counter. It covers relative jumps (taken always, or only when a carry or zero flag condition holds), jumps through the A, BA or Y registers, jumps through a displacement nibble held in memory, absolute and relative calls, a software interrupt, and four kinds of return.

Return addresses live on a word stack addressed by SP1. Each 16-bit entry covers the four nibbles that start at SP1×4, so the block uses a 16-bit stack port whose address is the nibble address of the low nibble. Flags live on a nibble stack addressed by SP2, which shares the single nibble memory port with data accesses. Instructions that take more than one cycle raise `busy`. While `busy` is high, fetch must hold and must not issue. The program counter changes only in the final cycle. The X register is kept outside the block. The data-storing return reports the updated X value through `x_we`/`x_new`, and the interrupt return reports the restored flags through `f_we`/`f_new`.

Top module: `branch_seq`

## Requirements
- R1: While `rst_n` is low and after it is released: `pc` = RESET_PC (default 0x0000), `sp1` = SP1_INIT (default 0x20), `sp2` = SP2_INIT (default 0x10), and `busy` = 0.
- R2: A code whose bits 12:8 are 00000 is an unconditional relative jump. It sets `pc` to pc + sign-extended bits 7:0 + 1 at the issue edge. The sum wraps modulo 2^16.
- R3: Codes with bits 12:8 of 00100 (C=1), 00101 (C=0), 00110 (Z=1) and 00111 (Z=0) are conditional jumps. When the condition holds they take the R2 target. Otherwise `pc` becomes pc + 1. Either way the jump completes in one cycle.
- R4: Code 0x1FF1 sets `pc` to pc + A + 1. Code 0x1FF0 sets it to pc + {B,A} + 1. Codes 0x1FF2 and 0x1FF3 load `pc` from Y. Each completes in one cycle.
- R5: A code with bits 12:6 of 1111101 reads the nibble at address bits 5:0 (zero-extended). It sets `pc` to pc + nibble + 1 in one cycle.
- R6: A code with bits 12:8 of 00011 is an absolute call to {0x00, bits 7:0}. A code with bits 12:8 of 00010 is a relative call to the R2 target. Each completes in one cycle. At the same edge it writes pc + 1 to the stack entry at (SP1−1)×4 and decrements SP1.
- R7: A code with bits 12:6 of 1111100 is a memory-indirect call that takes 2 cycles. It reads the nibble at bits 5:0, then pushes pc + 1 as in R6 and sets `pc` to pc + nibble + 1.
- R8: A code with bits 12:6 of 1111110 is a software interrupt that takes 3 cycles. Cycle 1 writes the F input to nibble address SP2−1 and decrements SP2. Cycle 2 pushes pc + 1 as in R6. Cycle 3 sets `pc` to 0x0100 + bits 5:0. The stack port and the nibble port are never written in the same cycle.
- R9: Codes 0x1FF8 and 0x1FFA pop `pc` from the entry at SP1×4 in 2 cycles. Code 0x1FFB pops it and adds 1 in 3 cycles. Every pop increments SP1 in its first cycle.
- R10: A code with bits 12:8 of 10001 pops `pc` in 3 cycles. Its second cycle writes bits 3:0 to nibble address X. Its third cycle writes bits 7:4 to X+1 and drives `x_we` with `x_new` = X+2.
- R11: Code 0x1FF9 pops `pc` in 2 cycles. Its second cycle drives `f_we` with `f_new` equal to the nibble at SP2, and increments SP2.
- R12: `busy` is high in every cycle after the first cycle of a multi-cycle instruction. `pc` holds until the final cycle, and `start` is ignored while `busy` is high.
- R13: Any other code advances `pc` by 1 in one cycle. It leaves `sp1` and `sp2` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue the instruction on `instr` |
| instr | input | 13 | Instruction word |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_f | input | 4 | Whole flag nibble, saved by the software interrupt |
| reg_a | input | 4 | A register |
| reg_b | input | 4 | B register |
| reg_x | input | 16 | X pointer |
| reg_y | input | 16 | Y register |
| mem_rdata | input | 4 | Nibble memory read data (combinational) |
| stk_rdata | input | 16 | Stack entry read data (combinational) |
| busy | output | 1 | Multi-cycle instruction in progress |
| pc | output | 16 | Program counter |
| sp1 | output | 8 | Address stack pointer |
| sp2 | output | 8 | Flag stack pointer |
| mem_addr | output | 16 | Nibble memory address |
| mem_we | output | 1 | Nibble memory write enable |
| mem_wdata | output | 4 | Nibble memory write data |
| stk_addr | output | 10 | Nibble address of the stack entry's low nibble |
| stk_we | output | 1 | Stack entry write enable |
| stk_wdata | output | 16 | Stack entry write data |
| x_we | output | 1 | Update X |
| x_new | output | 16 | New X value |
| f_we | output | 1 | Update flags |
| f_new | output | 4 | Restored flag nibble |

## Verification
A wrong step counter or a wrongly latched kind shows at once in `busy`. It also changes how many cycles pass before `pc` moves, and the bench checks this at each intermediate cycle. A stack pointer that drifts by one is not visible on the spot. It shows when the next return pops an entry other than the one just pushed, so every call is paired with a later return and its popped value. Errors in the ordering of nibble writes show in the bench's memory model after the data-storing return and the interrupt.

// File: rtl/branch_seq.sv
module branch_seq #(
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter logic [7:0]  SP1_INIT = 8'h20,
  parameter logic [7:0]  SP2_INIT = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [12:0] instr,
  input  logic        flag_c,
  input  logic        flag_z,
  input  logic [3:0]  flag_f,
  input  logic [3:0]  reg_a,
  input  logic [3:0]  reg_b,
  input  logic [15:0] reg_x,
  input  logic [15:0] reg_y,
  input  logic [3:0]  mem_rdata,
  input  logic [15:0] stk_rdata,
  output logic        busy,
  output logic [15:0] pc,
  output logic [7:0]  sp1,
  output logic [7:0]  sp2,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic [3:0]  mem_wdata,
  output logic [9:0]  stk_addr,
  output logic        stk_we,
  output logic [15:0] stk_wdata,
  output logic        x_we,
  output logic [15:0] x_new,
  output logic        f_we,
  output logic [3:0]  f_new
);

  typedef enum logic [3:0] {
    K_OTHER, K_JR, K_JCC, K_JA, K_JBA, K_JY, K_JM, K_CALZ,
    K_CALR, K_CALM, K_INT, K_RET, K_RETS, K_RETD, K_RETI
  } kind_t;

  kind_t       kind, op_q, op_d;
  logic [15:0] pc_q, pc_d, ret_q, ret_d, x_q, x_d;
  logic [7:0]  sp1_q, sp1_d, sp2_q, sp2_d, arg_q, arg_d;
  logic [1:0]  step_q, step_d;

  wire        issue = start && step_q == 2'd0;
  wire [15:0] rel8  = {{8{instr[7]}}, instr[7:0]};
  wire [15:0] pc_p1 = pc_q + 16'd1;
  wire [7:0]  sp1_m = sp1_q - 8'd1;
  wire [7:0]  sp2_m = sp2_q - 8'd1;
  wire        take  = instr[9] ? (flag_z ^ instr[8]) : (flag_c ^ instr[8]);

  assign busy = step_q != 2'd0;
  assign pc   = pc_q;
  assign sp1  = sp1_q;
  assign sp2  = sp2_q;

  always_comb begin
    kind = K_OTHER;
    case (instr[12:8])
      5'b00000: kind = K_JR;
      5'b00100, 5'b00101, 5'b00110, 5'b00111: kind = K_JCC;
      5'b00011: kind = K_CALZ;
      5'b00010: kind = K_CALR;
      5'b10001: kind = K_RETD;
      default: ;
    endcase
    if (instr[12:7] == 6'b111110) kind = instr[6] ? K_JM : K_CALM;
    if (instr[12:6] == 7'b1111110) kind = K_INT;
    if (instr[12:4] == 9'h1FF) begin
      case (instr[3:0])
        4'b0001: kind = K_JA;
        4'b0000: kind = K_JBA;
        4'b0010, 4'b0011: kind = K_JY;
        4'b1000, 4'b1010: kind = K_RET;
        4'b1011: kind = K_RETS;
        4'b1001: kind = K_RETI;
        default: ;
      endcase
    end
  end

  always_comb begin
    pc_d = pc_q; sp1_d = sp1_q; sp2_d = sp2_q; step_d = step_q;
    op_d = op_q; arg_d = arg_q; ret_d = ret_q; x_d = x_q;
    mem_addr = 16'h0000; mem_we = 1'b0; mem_wdata = 4'h0;
    stk_addr = {sp1_q, 2'b00}; stk_we = 1'b0; stk_wdata = pc_p1;
    x_we = 1'b0; x_new = x_q + 16'd2; f_we = 1'b0; f_new = mem_rdata;
    if (issue) begin
      op_d = kind; arg_d = instr[7:0];
      case (kind)
        K_JR:  pc_d = pc_q + rel8 + 16'd1;
        K_JCC: pc_d = take ? pc_q + rel8 + 16'd1 : pc_p1;
        K_JA:  pc_d = pc_q + {12'h000, reg_a} + 16'd1;
        K_JBA: pc_d = pc_q + {8'h00, reg_b, reg_a} + 16'd1;
        K_JY:  pc_d = reg_y;
        K_JM: begin
          mem_addr = {10'h000, instr[5:0]};
          pc_d = pc_q + {12'h000, mem_rdata} + 16'd1;
        end
        K_CALZ, K_CALR: begin
          stk_addr = {sp1_m, 2'b00}; stk_we = 1'b1; sp1_d = sp1_m;
          pc_d = (kind == K_CALZ) ? {8'h00, instr[7:0]} : pc_q + rel8 + 16'd1;
        end
        K_CALM: begin
          mem_addr = {10'h000, instr[5:0]};
          arg_d = {4'h0, mem_rdata}; step_d = 2'd1;
        end
        K_INT: begin
          mem_addr = {8'h00, sp2_m}; mem_we = 1'b1; mem_wdata = flag_f;
          sp2_d = sp2_m; arg_d = {2'b00, instr[5:0]}; step_d = 2'd1;
        end
        K_RET, K_RETS, K_RETD, K_RETI: begin
          ret_d = stk_rdata; sp1_d = sp1_q + 8'd1; x_d = reg_x; step_d = 2'd1;
        end
        default: pc_d = pc_p1;
      endcase
    end else if (busy) begin
      case (op_q)
        K_CALM: begin
          stk_addr = {sp1_m, 2'b00}; stk_we = 1'b1; sp1_d = sp1_m;
          pc_d = pc_q + {8'h00, arg_q} + 16'd1; step_d = 2'd0;
        end
        K_INT: begin
          if (step_q == 2'd1) begin
            stk_addr = {sp1_m, 2'b00}; stk_we = 1'b1; sp1_d = sp1_m; step_d = 2'd2;
          end else begin
            pc_d = 16'h0100 + {8'h00, arg_q}; step_d = 2'd0;
          end
        end
        K_RETS: begin
          if (step_q == 2'd1) step_d = 2'd2;
          else begin pc_d = ret_q + 16'd1; step_d = 2'd0; end
        end
        K_RETD: begin
          mem_we = 1'b1;
          if (step_q == 2'd1) begin
            mem_addr = x_q; mem_wdata = arg_q[3:0]; step_d = 2'd2;
          end else begin
            mem_addr = x_q + 16'd1; mem_wdata = arg_q[7:4];
            x_we = 1'b1; pc_d = ret_q; step_d = 2'd0;
          end
        end
        K_RETI: begin
          mem_addr = {8'h00, sp2_q}; f_we = 1'b1; sp2_d = sp2_q + 8'd1;
          pc_d = ret_q; step_d = 2'd0;
        end
        default: begin pc_d = ret_q; step_d = 2'd0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC; sp1_q <= SP1_INIT; sp2_q <= SP2_INIT; step_q <= 2'd0;
      op_q <= K_OTHER; arg_q <= 8'h00; ret_q <= 16'h0000; x_q <= 16'h0000;
    end else begin
      pc_q <= pc_d; sp1_q <= sp1_d; sp2_q <= sp2_d; step_q <= step_d;
      op_q <= op_d; arg_q <= arg_d; ret_q <= ret_d; x_q <= x_d;
    end
  end

  // R6
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |=> (sp1 + 8'd1) == $past(sp1));

  // R8
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && mem_we));

  // R10
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_we |-> (mem_we && x_new == mem_addr + 16'd1));

  // R11
  f_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_we |=> sp2 == $past(sp2) + 8'd1);

  // R12
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> pc == $past(pc));

endmodule

// File: tb/branch_seq_tb.sv
`timescale 1ns/1ps
module branch_seq_tb;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [12:0] instr = 13'h0;
  logic        flag_c = 1'b0, flag_z = 1'b0;
  logic [3:0]  flag_f = 4'h0, reg_a = 4'h0, reg_b = 4'h0;
  logic [15:0] reg_x = 16'h0, reg_y = 16'h0;
  logic [3:0]  mem_rdata;
  logic [15:0] stk_rdata;
  logic        busy, mem_we, stk_we, x_we, f_we;
  logic [15:0] pc, mem_addr, stk_wdata, x_new;
  logic [7:0]  sp1, sp2;
  logic [3:0]  mem_wdata, f_new;
  logic [9:0]  stk_addr;

  logic [3:0]  nmem [0:1023];
  logic [15:0] smem [0:255];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  branch_seq u_dut (.*);

  assign mem_rdata = nmem[mem_addr[9:0]];
  assign stk_rdata = smem[stk_addr[9:2]];
  always @(posedge clk) begin
    if (mem_we) nmem[mem_addr[9:0]] <= mem_wdata;
    if (stk_we) smem[stk_addr[9:2]] <= stk_wdata;
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [12:0] code);
    @(negedge clk); start = 1'b1; instr = code;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic t_reset;
    chk("R1 pc", pc, 16'h0000); chk("R1 sp1", {8'h0, sp1}, 16'h0020);
    chk("R1 sp2", {8'h0, sp2}, 16'h0010); chk("R1 busy", {15'h0, busy}, 16'h0);
  endtask

  task automatic t_jr;
    issue({5'b00000, 8'h05}); chk("R2 fwd", pc, 16'h0006);
    issue({5'b00000, 8'h80}); chk("R2 back wrap", pc, 16'hFF87);
    issue({5'b00000, 8'h7F}); chk("R2 fwd wrap", pc, 16'h0007);
  endtask

  task automatic t_jcc;
    flag_c = 1'b1; flag_z = 1'b0;
    issue({5'b00100, 8'h02}); chk("R3 C=1 taken", pc, 16'h000A);
    issue({5'b00101, 8'h02}); chk("R3 C=0 not taken", pc, 16'h000B);
    issue({5'b00110, 8'h03}); chk("R3 Z=1 not taken", pc, 16'h000C);
    issue({5'b00111, 8'h03}); chk("R3 Z=0 taken", pc, 16'h0010);
  endtask

  task automatic t_reg;
    reg_a = 4'hF; issue(13'h1FF1); chk("R4 A", pc, 16'h0020);
    reg_b = 4'h3; reg_a = 4'h1; issue(13'h1FF0); chk("R4 BA", pc, 16'h0052);
    reg_y = 16'h1234; issue(13'h1FF3); chk("R4 Y", pc, 16'h1234);
  endtask

  task automatic t_jm;
    issue({7'b1111101, 6'h2A}); chk("R5 mem jump", pc, 16'h123E);
    chk("R5 busy", {15'h0, busy}, 16'h0);
  endtask

  task automatic t_call;
    issue({5'b00011, 8'h55});
    chk("R6 CALZ pc", pc, 16'h0055); chk("R6 CALZ sp1", {8'h0, sp1}, 16'h001F);
    chk("R6 CALZ push", smem[8'h1F], 16'h123F);
    issue({5'b00010, 8'hFE});
    chk("R6 CALR pc", pc, 16'h0054); chk("R6 CALR push", smem[8'h1E], 16'h0056);
  endtask

  task automatic t_calm;
    issue({7'b1111100, 6'h05});
    chk("R7 busy", {15'h0, busy}, 16'h1); chk("R12 pc hold", pc, 16'h0054);
    step;
    chk("R7 pc", pc, 16'h005B); chk("R7 push", smem[8'h1D], 16'h0055);
    chk("R7 sp1", {8'h0, sp1}, 16'h001D); chk("R7 done", {15'h0, busy}, 16'h0);
  endtask

  task automatic t_int;
    flag_f = 4'hA;
    issue({7'b1111110, 6'h15});
    chk("R8 F saved", {12'h0, nmem[10'h00F]}, 16'h000A);
    chk("R8 sp2", {8'h0, sp2}, 16'h000F); chk("R12 pc hold", pc, 16'h005B);
    step;
    chk("R8 push", smem[8'h1C], 16'h005C); chk("R8 busy2", {15'h0, busy}, 16'h1);
    chk("R12 pc hold 2", pc, 16'h005B);
    step;
    chk("R8 vector", pc, 16'h0115); chk("R8 done", {15'h0, busy}, 16'h0);
  endtask

  task automatic t_reti;
    issue(13'h1FF9);
    chk("R11 sp1", {8'h0, sp1}, 16'h001D);
    chk("R11 f_we", {15'h0, f_we}, 16'h1); chk("R11 f_new", {12'h0, f_new}, 16'h000A);
    step;
    chk("R11 pc", pc, 16'h005C); chk("R11 sp2", {8'h0, sp2}, 16'h0010);
  endtask

  task automatic t_ret;
    issue(13'h1FF8); chk("R9 busy", {15'h0, busy}, 16'h1);
    step; chk("R9 RET pc", pc, 16'h0055); chk("R9 RET sp1", {8'h0, sp1}, 16'h001E);
    issue(13'h1FFB); chk("R9 RETS hold1", pc, 16'h0055);
    step; chk("R9 RETS busy2", {15'h0, busy}, 16'h1); chk("R9 RETS hold2", pc, 16'h0055);
    step; chk("R9 RETS pc", pc, 16'h0057); chk("R9 RETS sp1", {8'h0, sp1}, 16'h001F);
  endtask

  task automatic t_retd;
    reg_x = 16'h0200;
    issue({5'b10001, 8'hC7});
    step;
    chk("R10 low nibble", {12'h0, nmem[10'h200]}, 16'h0007);
    chk("R10 x_we", {15'h0, x_we}, 16'h1); chk("R10 x_new", x_new, 16'h0202);
    chk("R10 hold", pc, 16'h0057);
    step;
    chk("R10 high nibble", {12'h0, nmem[10'h201]}, 16'h000C);
    chk("R10 pc", pc, 16'h123F); chk("R10 sp1", {8'h0, sp1}, 16'h0020);
  endtask

  task automatic t_ignore;
    issue({5'b00011, 8'h10}); chk("R6 CALZ2", pc, 16'h0010);
    @(negedge clk); start = 1'b1; instr = 13'h1FF8;
    @(negedge clk); instr = {5'b00000, 8'h05};
    @(negedge clk); start = 1'b0;
    chk("R12 start ignored", pc, 16'h1240); chk("R12 sp1", {8'h0, sp1}, 16'h0020);
  endtask

  task automatic t_other;
    issue(13'h1FFE);
    chk("R13 pc", pc, 16'h1241); chk("R13 sp1", {8'h0, sp1}, 16'h0020);
    chk("R13 sp2", {8'h0, sp2}, 16'h0010);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) nmem[i] = 4'h0;
    for (int i = 0; i < 256; i++) smem[i] = 16'h0;
    nmem[10'h02A] = 4'h9;
    nmem[10'h005] = 4'h6;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    step;
    t_reset;
    t_jr; t_jcc; t_reg; t_jm; t_call; t_calm; t_int; t_reti; t_ret; t_retd;
    t_ignore; t_other;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule